// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the SPI slave pins and the command engine of a serial memory and handles the pause input. It samples the chip select, serial clock and active-low pause pin with the system clock through a synchronizer. It gives the engine one-cycle enables for each accepted serial clock rising and falling edge, a freeze flag, and an output-enable override for the serial data output.

A pause may be requested at any time while the device is selected. It takes hold, and releases, only while the serial clock is low. A pause request made while the clock is high waits for the next falling edge. The falling edge that begins a pause is swallowed. The falling edge that ends a pause is passed on. The engine's shift position therefore continues exactly where it stopped. Deselecting the device clears the pause at once, so every transaction starts unpaused.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While rst_ni is low, all outputs are 0, and the pause is clear.
- R2: While selected and not paused, each serial clock rising edge gives exactly one one-cycle pulse on sck_rise_en_o, and each falling edge one pulse on sck_fall_en_o. The pulse appears SYNC_STAGES+1 system cycles after the pin changes.
- R3: A low on hold_ni while the serial clock is low starts the pause after the synchronizer delay. hold_o then goes to 1 and so_oe_o goes to 0.
- R4: A low on hold_ni while the serial clock is high leaves hold_o at 0 until the clock falls. That falling edge starts the pause and gives no sck_fall_en_o pulse.
- R5: A high on hold_ni while the serial clock is low ends the pause after the synchronizer delay. so_oe_o then returns to 1.
- R6: A high on hold_ni while the serial clock is high keeps the pause until the next falling edge. That edge ends it and gives one sck_fall_en_o pulse.
- R7: While paused, serial clock edges give no enable pulse.
- R8: While cs_ni is high, hold_o, so_oe_o and both enables are 0. After a reselect with hold_ni high, the device is unpaused and so_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_ni | input | 1 | Pause pin, active low |
| sck_rise_en_o | output | 1 | Accepted serial clock rising edge, one cycle |
| sck_fall_en_o | output | 1 | Accepted serial clock falling edge, one cycle |
| hold_o | output | 1 | Pause active; the engine freezes its shift state |
| so_oe_o | output | 1 | Serial output may drive; 0 forces high impedance |

## Verification
A reference model runs alongside the design and is compared on every system cycle. It is driven with plain byte clocking, and with pause requests made while the clock is low and while it is high. Requests made while the clock is low separate immediate entry and exit from entry and exit aligned to an edge. Requests made while the clock is high show whether the falling edge that begins a pause is swallowed and whether the one that ends it is passed. Clock bursts during a pause and a deselect in mid-pause show that edges are blocked and that the pause clears.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic hold_n;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q[0] <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sck_i;
  end
  assign rise_o = sck_i & ~prev_q;
  assign fall_o = ~sck_i & prev_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic rise_en_o,
  output logic fall_en_o,
  output logic hold_o,
  output logic so_oe_o
);
  logic hold_q, hold_d;

  // pause state may only move while the serial clock is low
  always_comb begin
    if (cs_n_i)      hold_d = 1'b0;
    else if (!sck_i) hold_d = ~hold_n_i;
    else             hold_d = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= 1'b0;
      rise_en_o <= 1'b0;
      fall_en_o <= 1'b0;
      so_oe_o   <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      rise_en_o <= rise_i & ~cs_n_i & ~hold_d;
      fall_en_o <= fall_i & ~cs_n_i & ~hold_d;
      so_oe_o   <= ~cs_n_i & ~hold_d;
    end
  end
  assign hold_o = hold_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic sck_rise_en_o,
  output logic sck_fall_en_o,
  output logic hold_o,
  output logic so_oe_o
);
  pins_t pins_raw, pins_s;
  logic  rise, fall;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, hold_n: hold_ni};

  spi_hold_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  spi_hold_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (pins_s.sck),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_hold_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (pins_s.cs_n),
    .sck_i    (pins_s.sck),
    .hold_n_i (pins_s.hold_n),
    .rise_i   (rise),
    .fall_i   (fall),
    .rise_en_o(sck_rise_en_o),
    .fall_en_o(sck_fall_en_o),
    .hold_o   (hold_o),
    .so_oe_o  (so_oe_o)
  );
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sck_s,
  input logic sck_rise_en_o,
  input logic sck_fall_en_o,
  input logic hold_o,
  input logic so_oe_o
);
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_en_o |=> !sck_rise_en_o);
  p_fall_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_en_o |=> !sck_fall_en_o);
  p_edges_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_rise_en_o && sck_fall_en_o));
  p_high_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && sck_s) |=> (hold_o == $past(hold_o)));
  p_quiet_in_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (!sck_rise_en_o && !sck_fall_en_o && !so_oe_o));
  p_desel_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!hold_o && !so_oe_o && !sck_rise_en_o && !sck_fall_en_o));
  always_comb begin
    if (!rst_ni) p_reset_quiet_r1: assert (!hold_o && !so_oe_o);
  end
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_s         (pins_s.cs_n),
  .sck_s        (pins_s.sck),
  .sck_rise_en_o(sck_rise_en_o),
  .sck_fall_en_o(sck_fall_en_o),
  .hold_o       (hold_o),
  .so_oe_o      (so_oe_o)
);

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
  localparam int SYNC = 2;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
  logic rise_en, fall_en, hold, so_oe;
  int checks = 0, errors = 0, cyc_cnt = 0, n_rise = 0, n_fall = 0;
  string tag = "R1";
  bit q_cs[$], q_sck[$], q_hn[$];
  bit m_prev, m_hold, m_rise, m_fall, m_oe;

  always #5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .sck_rise_en_o(rise_en), .sck_fall_en_o(fall_en), .hold_o(hold), .so_oe_o(so_oe));

  task automatic chk(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic void model_step(bit c, bit s, bit h);
    bit sc = q_cs[0], ss = q_sck[0], sh = q_hn[0];
    bit hd = sc ? 1'b0 : (!ss ? !sh : m_hold);
    m_rise = ss && !m_prev && !sc && !hd;
    m_fall = !ss && m_prev && !sc && !hd;
    m_oe = !sc && !hd;
    m_prev = ss;
    m_hold = hd;
    void'(q_cs.pop_front()); void'(q_sck.pop_front()); void'(q_hn.pop_front());
    q_cs.push_back(c); q_sck.push_back(s); q_hn.push_back(h);
  endfunction

  task automatic cyc(bit c, bit s, bit h);
    cs_n = c; sck = s; hold_n = h;
    model_step(c, s, h);
    @(negedge clk);
    chk(tag, "rise_en", rise_en, m_rise);
    chk(tag, "fall_en", fall_en, m_fall);
    chk(tag, "hold", hold, m_hold);
    chk(tag, "so_oe", so_oe, m_oe);
    if (rise_en) n_rise++;
    if (fall_en) n_fall++;
  endtask

  task automatic idle(int n, bit c, bit s, bit h);
    for (int i = 0; i < n; i++) cyc(c, s, h);
  endtask

  task automatic pulse(bit h);
    idle(3, 1'b0, 1'b1, h);
    idle(3, 1'b0, 1'b0, h);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SYNC; i++) begin q_cs.push_back(1); q_sck.push_back(0); q_hn.push_back(1); end
    repeat (3) @(negedge clk);
    chk("R1", "reset hold", hold, 1'b0);
    chk("R1", "reset so_oe", so_oe, 1'b0);
    chk("R1", "reset rise", rise_en, 1'b0);
    chk("R1", "reset fall", fall_en, 1'b0);
    rst_n = 1'b1;
    // R2: one byte of plain clocking
    tag = "R2";
    idle(4, 1'b0, 1'b0, 1'b1);
    n_rise = 0; n_fall = 0;
    for (int b = 0; b < 8; b++) pulse(1'b1);
    idle(4, 1'b0, 1'b0, 1'b1);
    chk("R2", "rise count==8", n_rise == 8, 1'b1);
    chk("R2", "fall count==8", n_fall == 8, 1'b1);
    // R3: pause with clock low
    tag = "R3";
    idle(4, 1'b0, 1'b0, 1'b0);
    chk("R3", "hold entered", hold, 1'b1);
    chk("R3", "so_oe off", so_oe, 1'b0);
    // R7: clock bursts ignored during pause
    tag = "R7";
    n_rise = 0; n_fall = 0;
    for (int b = 0; b < 3; b++) pulse(1'b0);
    chk("R7", "no edges in hold", (n_rise + n_fall) == 0, 1'b1);
    // R5: release with clock low
    tag = "R5";
    idle(4, 1'b0, 1'b0, 1'b1);
    chk("R5", "hold left", hold, 1'b0);
    chk("R5", "so_oe back", so_oe, 1'b1);
    // R4: request while clock high
    tag = "R4";
    idle(4, 1'b0, 1'b1, 1'b1);
    n_fall = 0;
    idle(5, 1'b0, 1'b1, 1'b0);
    chk("R4", "no hold while high", hold, 1'b0);
    idle(5, 1'b0, 1'b0, 1'b0);
    chk("R4", "hold at fall", hold, 1'b1);
    chk("R4", "entry fall swallowed", n_fall == 0, 1'b1);
    // R6: release while clock high
    tag = "R6";
    idle(4, 1'b0, 1'b1, 1'b0);
    n_rise = 0; n_fall = 0;
    idle(5, 1'b0, 1'b1, 1'b1);
    chk("R6", "hold kept while high", hold, 1'b1);
    idle(5, 1'b0, 1'b0, 1'b1);
    chk("R6", "hold left at fall", hold, 1'b0);
    chk("R6", "exit fall passed", n_fall == 1 && n_rise == 0, 1'b1);
    // R8: deselect in mid pause
    tag = "R8";
    idle(4, 1'b0, 1'b0, 1'b0);
    chk("R8", "hold before deselect", hold, 1'b1);
    idle(5, 1'b1, 1'b0, 1'b0);
    chk("R8", "deselect clears hold", hold, 1'b0);
    chk("R8", "deselect so_oe", so_oe, 1'b0);
    n_rise = 0;
    pulse(1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    idle(5, 1'b1, 1'b0, 1'b1);
    idle(5, 1'b0, 1'b0, 1'b1);
    chk("R8", "reselect unpaused", hold, 1'b0);
    chk("R8", "reselect so_oe", so_oe, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule